// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block models a single-port synchronous SRAM behind one shared bidirectional data bus. Every command passes through a two-stage pipeline. The data for a command occupies the bus one fixed slot later, whether the command is a read or a write. Because both directions use the same slot, reads and writes can follow one another on every enabled clock edge with no idle cycle for bus turnaround.

A command is taken on a rising edge when `stall` is low. It is either:
- a load, with a fresh address, a direction and a chip-select decode; or
- an advance, which repeats the last loaded operation at the next address of a 4-beat burst.

Bursts follow either a linear or an interleaved order. Holding `stall` high freezes the whole pipeline, including the word on the bus. `out_en_n` only gates the output drivers.

Write data is split into byte lanes, each with its own active-low enable. A lane is 9 bits when the data width is a multiple of 9, and 8 bits otherwise. Depth is a parameter and is kept small.

Top module: `zbt_sram_pipe`

## Requirements
- R1: After a rising edge with `rst` high, `data_io` is released (high impedance) and no command is pending.
- R2: A read is a load (`advance`=0) with `wr_n`=1 while selected, captured at enabled edge k. Its word is driven on `data_io` from enabled edge k+1 until enabled edge k+2, which is the command's bus slot. The word includes any write committed at edge k+1.
- R3: A write is a load with `wr_n`=0 while selected, captured at enabled edge k. It stores `data_io` sampled at enabled edge k+2. Lane i is bits [LANE_W*i +: LANE_W], and it is written only when `lane_we_n[i]` was 0 at edge k.
- R4: An edge with `stall`=1 is ignored. No command is captured, no write happens, the bus keeps its current value, and the edge does not count toward any latency.
- R5: The block is selected only when `sel_a_n`=0, `sel_b_n`=0 and `sel_c`=1; any other load is a deselect. A deselect leaves the bus high impedance in its own slot, and an earlier read still appears in its slot. Advances after a deselect load stay deselects.
- R6: Any mix of reads and writes on consecutive enabled edges streams with no dead slot, and the block never drives the bus in a write slot.
- R7: `out_en_n`=1 releases the bus at once without stopping the pipeline. Reads issued meanwhile still complete in their slots.
- R8: With `burst_ilv`=0, an advance n beats after a load (n = 1..3, wrapping) repeats that load's operation at the base address with its two low bits replaced by (base[1:0] + n) mod 4.
- R9: With `burst_ilv`=1, the two low address bits of an advance are base[1:0] XOR n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | 1 ignores the edge and freezes the pipeline |
| addr | input | ADDR_W | Word address for a load |
| wr_n | input | 1 | 1 = read, 0 = write |
| advance | input | 1 | 0 = load a new command, 1 = next burst beat |
| sel_a_n | input | 1 | Active-low select term |
| sel_b_n | input | 1 | Active-low select term |
| sel_c | input | 1 | Active-high select term |
| lane_we_n | input | DATA_W/LANE_W | Active-low per-lane write enables, taken with the command |
| out_en_n | input | 1 | Active-low output driver enable |
| burst_ilv | input | 1 | 0 = linear burst order, 1 = interleaved |
| data_io | inout | DATA_W | Shared data bus |

## Verification
The hardest case is a read that directly follows a write to the same address. The write's data is committed at the same edge at which the read fetches its word, so the stored word is not yet current. If a stall falls between the two commands, the timing shifts further. The bench drives back-to-back write/read pairs to identical addresses. It then runs a long random stream that mixes reads, writes, deselects, bursts and stalls over a small address space, so that such collisions recur under many slot alignments. Every slot is compared against a reference array that the bench updates in step with its own model of the pipeline.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
  typedef enum logic [1:0] {OP_NONE = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2} op_e;

  // low address bits of burst beat n from base bits
  function automatic logic [1:0] burst_lsb(input logic [1:0] base,
                                           input logic [1:0] n,
                                           input logic ilv);
    return ilv ? (base ^ n) : (base + n);
  endfunction
endpackage

// File: rtl/zbt_cmd_gen.sv
module zbt_cmd_gen
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              advance,
  input  logic              wr_n,
  input  logic              selected,
  input  logic              burst_ilv,
  input  logic [ADDR_W-1:0] addr_in,
  output op_e               cmd_op,
  output logic [ADDR_W-1:0] cmd_addr
);
  op_e               last_op;
  logic [ADDR_W-1:0] base;
  logic [1:0]        beat;
  logic [1:0]        beat_nxt;

  assign beat_nxt = beat + 2'd1;

  always_comb begin
    if (!advance) begin
      cmd_op   = selected ? (wr_n ? OP_RD : OP_WR) : OP_NONE;
      cmd_addr = addr_in;
    end else begin
      cmd_op   = last_op;
      cmd_addr = {base[ADDR_W-1:2], burst_lsb(base[1:0], beat_nxt, burst_ilv)};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_op <= OP_NONE;
      base    <= '0;
      beat    <= '0;
    end else if (step) begin
      if (!advance) begin
        last_op <= cmd_op;
        base    <= addr_in;
        beat    <= '0;
      end else begin
        beat    <= beat_nxt;
      end
    end
  end
endmodule

// File: rtl/zbt_lane_ram.sv
module zbt_lane_ram #(
  parameter int W      = 9,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [W-1:0]      rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= (wr_en && wr_addr == rd_addr) ? wr_data : mem[rd_addr];
  end
endmodule

// File: rtl/zbt_sram_pipe.sv
module zbt_sram_pipe
  import zbt_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 4,
  localparam int LANE_W = (DATA_W % 9 == 0) ? 9 : 8,
  localparam int LANES  = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stall,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_n,
  input  logic              advance,
  input  logic              sel_a_n,
  input  logic              sel_b_n,
  input  logic              sel_c,
  input  logic [LANES-1:0]  lane_we_n,
  input  logic              out_en_n,
  input  logic              burst_ilv,
  inout  wire  [DATA_W-1:0] data_io
);
  logic              step;
  logic              selected;
  op_e               cmd_op;
  logic [ADDR_W-1:0] cmd_addr;

  op_e               s1_op, s2_op;
  logic [ADDR_W-1:0] s1_addr, s2_addr;
  logic [LANES-1:0]  s1_lwe_n, s2_lwe_n;
  logic              drive_q;
  logic [DATA_W-1:0] rd_word;

  assign step     = !stall;
  assign selected = !sel_a_n && !sel_b_n && sel_c;

  zbt_cmd_gen #(.ADDR_W(ADDR_W)) i_cmd_gen (
    .clk      (clk),
    .rst      (rst),
    .step     (step),
    .advance  (advance),
    .wr_n     (wr_n),
    .selected (selected),
    .burst_ilv(burst_ilv),
    .addr_in  (addr),
    .cmd_op   (cmd_op),
    .cmd_addr (cmd_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_op    <= OP_NONE;
      s2_op    <= OP_NONE;
      s1_addr  <= '0;
      s2_addr  <= '0;
      s1_lwe_n <= '1;
      s2_lwe_n <= '1;
      drive_q  <= 1'b0;
    end else if (step) begin
      s1_op    <= cmd_op;
      s1_addr  <= cmd_addr;
      s1_lwe_n <= lane_we_n;
      s2_op    <= s1_op;
      s2_addr  <= s1_addr;
      s2_lwe_n <= s1_lwe_n;
      drive_q  <= (s1_op == OP_RD);
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    zbt_lane_ram #(.W(LANE_W), .ADDR_W(ADDR_W)) i_ram (
      .clk    (clk),
      .wr_en  (step && s2_op == OP_WR && !s2_lwe_n[g]),
      .wr_addr(s2_addr),
      .wr_data(data_io[g*LANE_W +: LANE_W]),
      .rd_en  (step && s1_op == OP_RD),
      .rd_addr(s1_addr),
      .rd_data(rd_word[g*LANE_W +: LANE_W])
    );
  end

  assign data_io = (drive_q && !out_en_n) ? rd_word : {DATA_W{1'bz}};
endmodule

// File: rtl/zbt_sram_pipe_chk.sv
module zbt_sram_pipe_chk
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              stall,
  input logic              advance,
  input logic              drive_q,
  input op_e               s1_op,
  input op_e               s2_op,
  input logic [ADDR_W-1:0] s1_addr
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !drive_q); // R1

  AST_READ_SLOT: assert property (@(posedge clk) disable iff (rst)
    (!stall && s1_op == OP_RD) |=> drive_q); // R2

  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (rst)
    stall |=> ($stable(drive_q) && $stable(s1_op) && $stable(s2_op))); // R4

  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!stall && s1_op != OP_RD) |=> !drive_q); // R5

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst)
    drive_q |-> (s2_op == OP_RD)); // R6

  AST_BURST_UPPER: assert property (@(posedge clk) disable iff (rst)
    (!stall && advance) |=> $stable(s1_addr[ADDR_W-1:2])); // R8
endmodule

bind zbt_sram_pipe zbt_sram_pipe_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk    (clk),
  .rst    (rst),
  .stall  (stall),
  .advance(advance),
  .drive_q(drive_q),
  .s1_op  (s1_op),
  .s2_op  (s2_op),
  .s1_addr(s1_addr)
);

// File: tb/test_zbt_sram_pipe.sv
module test_zbt_sram_pipe;
  localparam int CLK_P = 10;
  localparam int DW    = 18;
  localparam int AW    = 4;
  localparam int LW    = 9;
  localparam int NB    = DW / LW;
  localparam int DEPTH = 1 << AW;
  localparam bit [2:0] SEL_ON = 3'b001;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stall = 1'b0, wr_n = 1'b1, advance = 1'b0;
  logic sel_a_n = 1'b1, sel_b_n = 1'b1, sel_c = 1'b0;
  logic out_en_n = 1'b0, burst_ilv = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [NB-1:0] lane_we_n = '1;
  logic tb_en = 1'b0;
  logic [DW-1:0] tb_val = '0;
  wire  [DW-1:0] data_io;

  assign data_io = tb_en ? tb_val : {DW{1'bz}};
  for (genvar g = 0; g < DW; g++) begin : g_pu
    pullup (data_io[g]);
  end

  zbt_sram_pipe #(.DATA_W(DW), .ADDR_W(AW)) i_zbt_sram_pipe (
    .clk(clk), .rst(rst), .stall(stall), .addr(addr), .wr_n(wr_n),
    .advance(advance), .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .sel_c(sel_c),
    .lane_we_n(lane_we_n), .out_en_n(out_en_n), .burst_ilv(burst_ilv),
    .data_io(data_io)
  );

  always #(CLK_P/2) clk = ~clk;

  int nchk = 0, nerr = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  // reference model: 0 none, 1 read, 2 write
  int p1k = 0, p2k = 0, mk = 0;
  logic [AW-1:0] p1a = '0, p2a = '0, mb = '0;
  logic [NB-1:0] p1w = '1, p2w = '1;
  logic [DW-1:0] p1d = '0, p2d = '0;
  logic [1:0] mc = '0;
  logic [DW-1:0] ref_mem [DEPTH];

  function automatic logic [DW-1:0] rnd();
    return DW'($urandom) & ~DW'(1);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_bus();
    logic [DW-1:0] exp;
    if (p2k == 2) return;
    exp = (p2k == 1 && !out_en_n) ? ref_mem[p2a] : '1;
    chk(data_io === exp, cur_req, data_io, exp);
  endtask

  task automatic issue(input bit st, input bit ld, input bit wr, input bit [2:0] sel,
                       input logic [AW-1:0] a, input logic [NB-1:0] lw,
                       input logic [DW-1:0] d);
    int nk;
    logic [AW-1:0] na;
    logic [1:0] n;
    stall = st; advance = !ld; wr_n = !wr;
    {sel_a_n, sel_b_n, sel_c} = sel;
    addr = a; lane_we_n = lw;
    if (ld) begin
      nk = (sel == SEL_ON) ? (wr ? 2 : 1) : 0;
      na = a;
    end else begin
      n  = mc + 2'd1;
      nk = mk;
      na = {mb[AW-1:2], burst_ilv ? (mb[1:0] ^ n) : (mb[1:0] + n)};
    end
    @(posedge clk);
    if (!st) begin
      if (p2k == 2)
        for (int i = 0; i < NB; i++)
          if (!p2w[i]) ref_mem[p2a][i*LW +: LW] = p2d[i*LW +: LW];
      p2k = p1k; p2a = p1a; p2w = p1w; p2d = p1d;
      p1k = nk;  p1a = na;  p1w = lw;  p1d = d;
      if (ld) begin mk = nk; mb = a; mc = '0; end
      else mc = mc + 2'd1;
    end
    #1;
    tb_en = (p2k == 2);
    tb_val = p2d;
    @(negedge clk);
    check_bus();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) issue(0, 1, 0, 3'b100, '0, '1, '0);
  endtask

  task automatic t_reset();
    cur_req = "R1";
    rst = 1'b1; tb_en = 1'b0;
    @(posedge clk); #1;
    chk(data_io === '1, "R1", data_io, '1);
    @(negedge clk);
    chk(data_io === '1, "R1", data_io, '1);
    rst = 1'b0;
    p1k = 0; p2k = 0; mk = 0; mb = '0; mc = '0;
    idle(3);
  endtask

  task automatic t_basic();
    cur_req = "R6";
    for (int a = 0; a < DEPTH; a++) issue(0, 1, 1, SEL_ON, AW'(a), '0, rnd());
    cur_req = "R2";
    for (int a = 0; a < DEPTH; a++) issue(0, 1, 0, SEL_ON, AW'(a), '1, '0);
    cur_req = "R6";
    for (int i = 0; i < 8; i++) begin
      issue(0, 1, 1, SEL_ON, AW'(i), '0, rnd());
      issue(0, 1, 0, SEL_ON, AW'(i), '1, '0);
    end
    idle(2);
  endtask

  task automatic t_lanes();
    cur_req = "R3";
    issue(0, 1, 1, SEL_ON, 4'd3, 2'b00, 18'h2A5A4);
    issue(0, 1, 1, SEL_ON, 4'd3, 2'b10, 18'h15AB2);
    issue(0, 1, 0, SEL_ON, 4'd3, 2'b11, '0);
    issue(0, 1, 1, SEL_ON, 4'd3, 2'b01, 18'h3FE00);
    issue(0, 1, 1, SEL_ON, 4'd3, 2'b11, 18'h00000);
    issue(0, 1, 0, SEL_ON, 4'd3, 2'b11, '0);
    idle(2);
    chk(ref_mem[3] === 18'h3FEB2, "R3", ref_mem[3], 18'h3FEB2);
    issue(0, 1, 0, SEL_ON, 4'd3, 2'b11, '0);
    idle(2);
  endtask

  task automatic t_stall();
    cur_req = "R4";
    issue(0, 1, 0, SEL_ON, 4'd5, '1, '0);
    issue(0, 1, 1, SEL_ON, 4'd6, '0, rnd());
    issue(1, 1, 1, SEL_ON, 4'd7, '0, rnd());
    issue(1, 1, 0, SEL_ON, 4'd8, '1, '0);
    issue(0, 1, 0, SEL_ON, 4'd6, '1, '0);
    for (int i = 0; i < 40; i++)
      issue(($urandom % 3) == 0, 1, $urandom % 2, SEL_ON, AW'($urandom), '0, rnd());
    idle(2);
  endtask

  task automatic t_desel();
    cur_req = "R5";
    issue(0, 1, 0, SEL_ON, 4'd1, '1, '0);
    issue(0, 1, 0, 3'b000, 4'd2, '1, '0);
    issue(0, 1, 0, SEL_ON, 4'd2, '1, '0);
    issue(0, 1, 0, 3'b011, 4'd3, '1, '0);
    issue(0, 1, 1, 3'b101, 4'd4, '0, rnd());
    issue(0, 0, 0, SEL_ON, 4'd9, '1, '0);
    issue(0, 1, 0, 3'b111, 4'd4, '1, '0);
    issue(0, 1, 0, SEL_ON, 4'd4, '1, '0);
    idle(3);
  endtask

  task automatic t_oe();
    cur_req = "R7";
    out_en_n = 1'b1;
    issue(0, 1, 0, SEL_ON, 4'd10, '1, '0);
    issue(0, 1, 0, SEL_ON, 4'd11, '1, '0);
    out_en_n = 1'b0; #1;
    chk(data_io === ref_mem[10], "R7", data_io, ref_mem[10]);
    out_en_n = 1'b1; #1;
    chk(data_io === '1, "R7", data_io, '1);
    out_en_n = 1'b0;
    issue(0, 1, 0, SEL_ON, 4'd12, '1, '0);
    idle(2);
  endtask

  task automatic t_burst(input bit ilv, input logic [AW-1:0] base);
    cur_req = ilv ? "R9" : "R8";
    burst_ilv = ilv;
    issue(0, 1, 1, SEL_ON, base, '0, rnd());
    for (int i = 0; i < 3; i++) issue(0, 0, 0, 3'b100, '0, '0, rnd());
    issue(0, 1, 0, SEL_ON, base, '1, '0);
    for (int i = 0; i < 5; i++) issue(0, 0, 1, 3'b100, '0, '1, '0);
    for (int a = 0; a < 4; a++) issue(0, 1, 0, SEL_ON, {base[AW-1:2], 2'(a)}, '1, '0);
    idle(2);
    burst_ilv = 1'b0;
  endtask

  task automatic t_mix();
    cur_req = "R6";
    for (int i = 0; i < 400; i++) begin
      burst_ilv = $urandom % 2;
      out_en_n  = ($urandom % 8) == 0;
      issue(($urandom % 5) == 0, ($urandom % 4) != 0, $urandom % 2,
            (($urandom % 6) == 0) ? 3'b000 : SEL_ON, AW'($urandom),
            NB'($urandom), rnd());
    end
    out_en_n = 1'b0;
    idle(3);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_basic();
    t_lanes();
    t_stall();
    t_desel();
    t_oe();
    t_burst(1'b0, 4'd6);
    t_burst(1'b1, 4'd9);
    t_mix();
    t_reset();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule